// File: doc/BRIEF.md
# Write-recovery idle-cycle controller

This block guards one chip-select space of an external memory bus. CPU-side requests pass through a valid/ready handshake with a direction flag. Each granted request is forwarded to the bus as a one-cycle start pulse with a write-enable. After a write, the block withholds ready for a programmable number of idle bus cycles, so that the device on the space can recover before the next read or write. After a read, no gap is inserted.

The gap length and the standby behaviour of the shared strobe pins come from a 32-bit control register held inside the block. That register is restored only by the power-on reset; a manual reset or standby leaves it untouched. Until software has written the register once, the block grants only requests aimed at the boot area. Any other granted request is dropped and flagged.

Top module: `idle_gap_ctrl`

## Requirements
- R1: The gap code is held in register bits 30:28. After a write is forwarded, req_ready stays low for 0, 1, 2, 4, 6, 8, 10 or 12 cycles for codes 0 to 7 respectively, and then returns high.
- R2: After a read is forwarded, req_ready stays high, so the next request is granted without a gap.
- R3: A power-on reset (por_rst high at a clock edge) loads the register with 0x36DB0600. The gap after a write is then 4 cycles, req_ready is high, and bus_go and acc_denied are low.
- R4: A manual reset (man_rst high at a clock edge) ends any gap in progress, so req_ready is high afterwards. It leaves the register contents and the "configured" state unchanged.
- R5: strobe_oe is registered. One cycle after a cycle with standby low it is 1. One cycle after a cycle with standby high it equals register bit 31 (0 means the strobe pins float, 1 means they stay driven).
- R6: Register bit 27 and bits 7:0 are reserved. They always read 0, and writes to them have no effect.
- R7: A register write made while a gap is counting does not change that gap's length. The next forwarded write uses the new code.
- R8: Until the first register write after power-on, a granted request with req_area_boot low is not forwarded: bus_go stays low, acc_denied pulses one cycle after the grant, and no gap follows. Boot-area requests are forwarded. After the first register write, all requests are forwarded.
- R9: If no request arrives until a gap has ended, a later request sees req_ready high at once and is granted at the first edge.
- R10: A request is granted at an edge where req_valid and req_ready are both high. If forwarded, bus_go is high for exactly the following cycle, with bus_we equal to the granted req_write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Synchronous active-high power-on reset |
| man_rst | input | 1 | Synchronous active-high manual reset |
| standby | input | 1 | Standby or bus-release state |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | Request direction, 1 = write |
| req_area_boot | input | 1 | Request targets the boot area |
| req_ready | output | 1 | Request may be granted this cycle |
| bus_go | output | 1 | One-cycle start of a forwarded access |
| bus_we | output | 1 | Direction of the forwarded access |
| acc_denied | output | 1 | One-cycle flag for a dropped request |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register contents |
| strobe_oe | output | 1 | Output enable for the shared strobe pins |

## Verification
A grant happens at the edge where valid meets ready. bus_go, bus_we and acc_denied are checked at the falling edge right after that grant edge. The gap is measured by counting falling edges, starting at that same falling edge, at which req_ready is still low. The count must equal the decoded code exactly, and a read must give zero. Register effects are read back on cfg_rdata one edge after the write strobe. strobe_oe is sampled one edge after standby or bit 31 changes. All inputs are driven and all outputs are sampled on falling edges, clear of the active edge.

// File: rtl/idle_gap_pkg.sv
package idle_gap_pkg;
  localparam int GAP_W = 4;

  // Non-linear code-to-gap mapping: 0,1,2 stay; 3..7 become 2*(code-1).
  function automatic logic [GAP_W-1:0] gap_cycles(input logic [2:0] code);
    logic [2:0] dec;
    dec = code - 3'd1;
    if (code <= 3'd2) gap_cycles = {1'b0, code};
    else              gap_cycles = {dec, 1'b0};
  endfunction
endpackage

// File: rtl/idle_gap_cfg.sv
module idle_gap_cfg #(
  parameter int          DATA_W   = 32,
  parameter logic [31:0] INIT_VAL = 32'h36DB_0600,
  parameter logic [31:0] RW_MASK  = 32'hF7FF_FF00
) (
  input  logic              clk,
  input  logic              por_rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              configured
);
  localparam logic [DATA_W-1:0] MASK = RW_MASK[DATA_W-1:0];
  localparam logic [DATA_W-1:0] INIT = INIT_VAL[DATA_W-1:0] & MASK;

  logic [DATA_W-1:0] ctl_q;
  logic              cfg_q;

  always_ff @(posedge clk) begin
    if (por_rst) begin
      ctl_q <= INIT;
      cfg_q <= 1'b0;
    end else if (we) begin
      ctl_q <= wdata & MASK;
      cfg_q <= 1'b1;
    end
  end

  assign rdata      = ctl_q;
  assign configured = cfg_q;
endmodule

// File: rtl/idle_gap_timer.sv
module idle_gap_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             ready
);
  logic [CNT_W-1:0] cnt_q;
  logic             rdy_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt_q <= '0;
      rdy_q <= 1'b1;
    end else if (load) begin
      cnt_q <= load_val;
      rdy_q <= (load_val == '0);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      rdy_q <= (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});
    end
  end

  assign ready = rdy_q;
endmodule

// File: rtl/idle_gap_ctrl.sv
module idle_gap_ctrl #(
  parameter int          DATA_W   = 32,
  parameter logic [31:0] INIT_VAL = 32'h36DB_0600,
  parameter logic [31:0] RW_MASK  = 32'hF7FF_FF00,
  parameter int          CODE_LSB = 28,
  parameter int          OE_BIT   = 31
) (
  input  logic              clk,
  input  logic              por_rst,
  input  logic              man_rst,
  input  logic              standby,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_area_boot,
  output logic              req_ready,
  output logic              bus_go,
  output logic              bus_we,
  output logic              acc_denied,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              strobe_oe
);
  import idle_gap_pkg::*;

  logic              configured;
  logic              grant, allowed;
  logic [2:0]        gap_code;
  logic [GAP_W-1:0]  gap_len;

  idle_gap_cfg #(
    .DATA_W(DATA_W), .INIT_VAL(INIT_VAL), .RW_MASK(RW_MASK)
  ) u_cfg (
    .clk(clk), .por_rst(por_rst), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .configured(configured)
  );

  assign grant    = req_valid && req_ready;
  assign allowed  = req_area_boot || configured;
  assign gap_code = cfg_rdata[CODE_LSB +: 3];
  assign gap_len  = gap_cycles(gap_code);

  idle_gap_timer #(.CNT_W(GAP_W)) u_timer (
    .clk(clk), .clr(por_rst || man_rst),
    .load(grant && allowed && req_write),
    .load_val(gap_len), .ready(req_ready)
  );

  always_ff @(posedge clk) begin
    if (por_rst || man_rst) begin
      bus_go     <= 1'b0;
      bus_we     <= 1'b0;
      acc_denied <= 1'b0;
    end else begin
      bus_go     <= grant && allowed;
      acc_denied <= grant && !allowed;
      if (grant && allowed) bus_we <= req_write;
    end
  end

  always_ff @(posedge clk) begin
    if (por_rst) strobe_oe <= 1'b1;
    else         strobe_oe <= standby ? cfg_rdata[OE_BIT] : 1'b1;
  end
endmodule

// File: rtl/idle_gap_ctrl_chk.sv
module idle_gap_ctrl_chk #(
  parameter int          DATA_W  = 32,
  parameter logic [31:0] RW_MASK = 32'hF7FF_FF00,
  parameter int          OE_BIT  = 31
) (
  input logic              clk,
  input logic              por_rst,
  input logic              man_rst,
  input logic              standby,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_ready,
  input logic              bus_go,
  input logic              acc_denied,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic              strobe_oe
);
  localparam logic [DATA_W-1:0] RSVD = ~RW_MASK[DATA_W-1:0];

  assert_rsvd_zero_R6: assert property (@(posedge clk) disable iff (por_rst)
    (cfg_rdata & RSVD) == '0);

  assert_fall_after_write_R1: assert property (@(posedge clk) disable iff (por_rst || man_rst)
    $fell(req_ready) |-> $past(req_valid && req_write));

  assert_read_no_gap_R2: assert property (@(posedge clk) disable iff (por_rst || man_rst)
    (req_valid && req_ready && !req_write) |=> req_ready);

  assert_go_needs_grant_R10: assert property (@(posedge clk) disable iff (por_rst || man_rst)
    bus_go |-> $past(req_valid && req_ready));

  assert_go_deny_excl_R8: assert property (@(posedge clk) disable iff (por_rst || man_rst)
    !(bus_go && acc_denied));

  assert_oe_awake_R5: assert property (@(posedge clk) disable iff (por_rst)
    !standby |=> strobe_oe);

  assert_oe_float_R5: assert property (@(posedge clk) disable iff (por_rst)
    (standby && !cfg_rdata[OE_BIT]) |=> !strobe_oe);
endmodule

bind idle_gap_ctrl idle_gap_ctrl_chk #(
  .DATA_W(DATA_W), .RW_MASK(RW_MASK), .OE_BIT(OE_BIT)
) u_chk (
  .clk(clk), .por_rst(por_rst), .man_rst(man_rst), .standby(standby),
  .req_valid(req_valid), .req_write(req_write), .req_ready(req_ready),
  .bus_go(bus_go), .acc_denied(acc_denied), .cfg_rdata(cfg_rdata),
  .strobe_oe(strobe_oe)
);

// File: tb/idle_gap_ctrl_bench.sv
module idle_gap_ctrl_bench;
  logic        clk = 1'b0;
  logic        por_rst = 1'b1, man_rst = 1'b0, standby = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_area_boot = 1'b0;
  logic        req_ready, bus_go, bus_we, acc_denied, strobe_oe;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  int          n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  idle_gap_ctrl u_idle_gap_ctrl (
    .clk(clk), .por_rst(por_rst), .man_rst(man_rst), .standby(standby),
    .req_valid(req_valid), .req_write(req_write), .req_area_boot(req_area_boot),
    .req_ready(req_ready), .bus_go(bus_go), .bus_we(bus_we),
    .acc_denied(acc_denied), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .strobe_oe(strobe_oe)
  );

  function automatic int exp_gap(input int code);
    int t[8] = '{0, 1, 2, 4, 6, 8, 10, 12};
    return t[code];
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [31:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // Issue one request; report wait before grant, gap after it and edge outputs.
  task automatic access(input logic wr, input logic boot, output int wait_n,
                        output int gap, output logic go, output logic we, output logic den);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_area_boot = boot;
    wait_n = 0;
    while (!req_ready) begin wait_n++; @(negedge clk); end
    @(negedge clk);
    req_valid = 1'b0;
    go = bus_go; we = bus_we; den = acc_denied;
    gap = 0;
    while (!req_ready && gap < 40) begin gap++; @(negedge clk); end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R3", "init value", cfg_rdata, 32'h36DB_0600);
    chk("R3", "ready after por", req_ready, 1);
    chk("R3", "bus_go after por", bus_go, 0);
    chk("R3", "denied after por", acc_denied, 0);
  endtask

  task automatic t_boot_gate();
    int w, g; logic go, we, den;
    access(1'b1, 1'b0, w, g, go, we, den);
    chk("R8", "non-boot denied", den, 1);
    chk("R8", "non-boot not forwarded", go, 0);
    chk("R8", "no gap after drop", g, 0);
    access(1'b1, 1'b1, w, g, go, we, den);
    chk("R8", "boot forwarded", go, 1);
    chk("R10", "bus_we on write", we, 1);
    chk("R3", "default gap", g, 4);
  endtask

  task automatic t_codes();
    int w, g; logic go, we, den;
    for (int c = 0; c < 8; c++) begin
      cfg_write(32'(c) << 28);
      access(1'b1, 1'b0, w, g, go, we, den);
      chk("R8", "forwarded after config", go, 1);
      chk("R1", $sformatf("gap for code %0d", c), g, exp_gap(c));
    end
  endtask

  task automatic t_reads();
    int w, g; logic go, we, den;
    cfg_write(32'h5000_0000);
    access(1'b0, 1'b0, w, g, go, we, den);
    chk("R10", "read forwarded", go, 1);
    chk("R10", "bus_we on read", we, 0);
    chk("R2", "no gap after read", g, 0);
    access(1'b0, 1'b0, w, g, go, we, den);
    chk("R2", "read after read no wait", w, 0);
    access(1'b1, 1'b0, w, g, go, we, den);
    chk("R1", "write gap code 5", g, 8);
    repeat (3) @(negedge clk);
    access(1'b0, 1'b0, w, g, go, we, den);
    chk("R9", "late request no wait", w, 0);
  endtask

  task automatic t_reserved();
    int w, g; logic go, we, den;
    cfg_write(32'hFFFF_FFFF);
    @(negedge clk);
    chk("R6", "reserved read zero", cfg_rdata, 32'hF7FF_FF00);
    access(1'b1, 1'b0, w, g, go, we, den);
    chk("R1", "gap code 7", g, 12);
  endtask

  task automatic t_midcount();
    int w, g; logic go, we, den;
    cfg_write(32'h7000_0000);
    fork
      access(1'b1, 1'b0, w, g, go, we, den);
      begin repeat (4) @(negedge clk); cfg_write(32'h1000_0000); end
    join
    chk("R7", "running gap unchanged", g, 12);
    access(1'b1, 1'b0, w, g, go, we, den);
    chk("R7", "next gap uses new code", g, 1);
  endtask

  task automatic t_manual();
    int w, g; logic go, we, den;
    cfg_write(32'h6000_0000);
    @(negedge clk); req_valid = 1'b1; req_write = 1'b1; req_area_boot = 1'b0;
    @(negedge clk); req_valid = 1'b0;
    chk("R1", "stall begun", req_ready, 0);
    man_rst = 1'b1;
    @(negedge clk); man_rst = 1'b0;
    chk("R4", "gap ended by manual reset", req_ready, 1);
    chk("R4", "register kept", cfg_rdata, 32'h6000_0000);
    access(1'b1, 1'b0, w, g, go, we, den);
    chk("R4", "configured state kept", go, 1);
    chk("R4", "gap code 6", g, 10);
  endtask

  task automatic t_standby();
    cfg_write(32'h0000_0000);
    @(negedge clk); standby = 1'b1;
    @(negedge clk);
    chk("R5", "float when bit31=0", strobe_oe, 0);
    cfg_write(32'h8000_0000);
    @(negedge clk);
    chk("R5", "driven when bit31=1", strobe_oe, 1);
    cfg_write(32'h0000_0000);
    standby = 1'b0;
    @(negedge clk);
    chk("R5", "driven when awake", strobe_oe, 1);
  endtask

  task automatic t_por_again();
    int w, g; logic go, we, den;
    @(negedge clk); por_rst = 1'b1;
    @(negedge clk); por_rst = 1'b0;
    chk("R3", "init after second por", cfg_rdata, 32'h36DB_0600);
    access(1'b0, 1'b0, w, g, go, we, den);
    chk("R8", "gate re-armed by por", den, 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        por_rst = 1'b0;
        t_reset();
        t_boot_gate();
        t_codes();
        t_reads();
        t_reserved();
        t_midcount();
        t_manual();
        t_standby();
        t_por_again();
      end
      begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule